// File: doc/BRIEF.md
# SPI Byte-Register Slave with Module Addressing

This block is an SPI slave, running on the system clock, that gives a host byte-wide access to a small set of control registers. Every transaction is two bytes long. The first byte is an opcode and the second is a data byte. The opcode holds three fields: a direction bit, a module selector and a register index. The module selector picks one of three register groups: system control, I/O control and sample-interface control. Each group has room for 32 registers.

Each group answers with its own constant version byte at index 0. The system group also holds a constant system version and a manufacturer code. The remaining registers drive control outputs: LEDs, PMOD direction and value, RF mode, sync-source selects, TX sample gap, debug modes, soft-sync values and sample-channel selects. Some registers mix writable fields with read-only fields. For example, the digital-pin register returns the live button and configuration inputs.

The SPI pins and the soft-reset pin are asynchronous to the system clock. They pass through two-flop synchronizers, and SCLK edges are found from the synchronized copy. SCLK therefore has to be much slower than the system clock; about 1 MHz is typical.

Top module: `spi_modreg_slave`

## Requirements
- R1: A frame is 16 SCLK rising edges in SPI mode 0, MSB first, while chip select is low. Byte one is the opcode: bit 7 = 1 means write and 0 means read, bits 6:5 select the module (0 system, 1 I/O, 2 sample interface, 3 reserved), and bits 4:0 give the index. Byte two is the data. A write takes effect once per frame, after the 16th bit.
- R2: On a read frame, MISO shifts out the addressed register value, MSB first, during the second byte. On a write frame and while chip select is high, MISO is 0.
- R3: Index 0 returns the module version: system 0x11, I/O 0x21, sample 0x31. System index 1 returns 0x05 and system index 2 returns 0x5A. All of these are read-only, and writes to them have no effect.
- R4: System index 6 is fully writable and reads back as written. Bits 3:0 drive `tx_gap_o`. Bits 4, 5, 6 and 7 drive `sync_src_o[0]`, `[1]`, `[2]` and `[3]`.
- R5: System index 5 keeps bits 2:0 on `dbg_mode_o`. System index 7 keeps bits 3:0 on `soft_sync_o`. Unused upper bits of both read as 0.
- R6: I/O index 1 keeps bits 1:0 on `io_dbg_o` and bits 4:2 on `rf_mode_o`. A write whose RF field is 6 or 7 leaves `rf_mode_o` unchanged but still updates the debug field.
- R7: I/O index 2 drives `led_o` from bits 1:0. A read returns bit 7 = `btn_i`, bits 6:3 = `cfg_i` and bit 2 = 0. Written bits 7:2 have no effect.
- R8: I/O index 3 drives `pmod_dir_o` and I/O index 4 drives `pmod_val_o`. Both are full bytes that read back as written.
- R9: Sample index 2 bit 0 drives `smp_chan_o` and sample index 3 bit 0 drives `smp_dir_o`. Each reads back in bit 0 with the other bits 0.
- R10: Reserved module 3, system index 3 (error status) and every undecoded index read 0x00. Writes to them change no output.
- R11: If chip select rises before 16 bits have arrived, the frame makes no write. Bits beyond the 16th are ignored.
- R12: A write to system index 4, or `soft_rst_n_i` held low, returns every writable register to 0. A write that falls in a clear cycle is lost. System index 4 reads 0.
- R13: Synchronous active-high `rst` drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | SPI serial clock (asynchronous) |
| mosi_i | input | 1 | SPI data from host |
| cs_n_i | input | 1 | SPI chip select, active low |
| miso_o | output | 1 | SPI data to host |
| soft_rst_n_i | input | 1 | Active-low register clear (asynchronous) |
| btn_i | input | 1 | Button level, read back in the digital-pin register |
| cfg_i | input | 4 | Configuration pins, read back in the digital-pin register |
| led_o | output | 2 | LED drive |
| pmod_dir_o | output | 8 | PMOD direction |
| pmod_val_o | output | 8 | PMOD value |
| rf_mode_o | output | 3 | RF mode, 0 to 5 |
| io_dbg_o | output | 2 | I/O debug mode |
| sync_src_o | output | 4 | Sync-source selects {TX high, TX low, RX high, RX low} |
| tx_gap_o | output | 4 | TX sample gap |
| dbg_mode_o | output | 3 | {sample-interface debug, FIFO pull debug, FIFO push debug} |
| soft_sync_o | output | 4 | Soft-sync values |
| smp_chan_o | output | 1 | Sample channel select |
| smp_dir_o | output | 1 | Sample direction select |

## Verification
The register write strobe at the end of a frame can land in the same cycle as a clear from the soft-reset pin, and the clear must win. The bench provokes this by holding the soft-reset pin low across a whole write frame to the PMOD direction register. It then releases the pin and judges the result at the `pmod_dir_o` port, which must still read 0. A register clear requested through the SPI frame itself is checked the same way, on the LED, PMOD and RF outputs.

// File: rtl/spi_modreg_pkg.sv
package spi_modreg_pkg;

    localparam int REG_W      = 8;
    localparam int IDX_W      = 5;
    localparam int MOD_W      = 2;
    localparam int BYTE_BITS  = 8;
    localparam int FRAME_BITS = 2 * BYTE_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [MOD_W-1:0] {
        MOD_SYS = 2'd0,
        MOD_IO  = 2'd1,
        MOD_SMP = 2'd2,
        MOD_RSV = 2'd3
    } mod_id_e;

    typedef struct packed {
        logic             wr;
        mod_id_e          mod;
        logic [IDX_W-1:0] idx;
    } opcode_t;

    // register indices
    localparam logic [IDX_W-1:0] IX_VER      = 5'd0;
    localparam logic [IDX_W-1:0] IX_SYS_VER  = 5'd1;
    localparam logic [IDX_W-1:0] IX_MANU     = 5'd2;
    localparam logic [IDX_W-1:0] IX_CLEAR    = 5'd4;
    localparam logic [IDX_W-1:0] IX_DBG      = 5'd5;
    localparam logic [IDX_W-1:0] IX_GAP_SYNC = 5'd6;
    localparam logic [IDX_W-1:0] IX_SSYNC    = 5'd7;
    localparam logic [IDX_W-1:0] IX_IO_MODE  = 5'd1;
    localparam logic [IDX_W-1:0] IX_IO_PINS  = 5'd2;
    localparam logic [IDX_W-1:0] IX_PMOD_DIR = 5'd3;
    localparam logic [IDX_W-1:0] IX_PMOD_VAL = 5'd4;
    localparam logic [IDX_W-1:0] IX_SMP_CHAN = 5'd2;
    localparam logic [IDX_W-1:0] IX_SMP_DIR  = 5'd3;

    localparam logic [2:0] RF_MODE_MAX = 3'd5;

    function automatic logic rf_mode_legal(input logic [2:0] m);
        return m <= RF_MODE_MAX;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic mosi_i,
    input  logic cs_n_i,
    input  logic srst_n_i,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic mosi_o,
    output logic cs_act_o,
    output logic clr_o
);
    localparam int NPIN = 4;
    // idle levels: sclk 0, mosi 0, cs_n 1, srst_n 1
    localparam logic [NPIN-1:0] IDLE = 4'b1100;

    logic [NPIN-1:0] raw;
    logic [NPIN-1:0] stg [STAGES];
    logic            sclk_prev;

    assign raw = {srst_n_i, cs_n_i, mosi_i, sclk_i};

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stg[s] <= IDLE;
                else if (s == 0)
                    stg[s] <= raw;
                else
                    stg[s] <= stg[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= stg[STAGES-1][0];
    end

    assign sclk_rise_o =  stg[STAGES-1][0] & ~sclk_prev;
    assign sclk_fall_o = ~stg[STAGES-1][0] &  sclk_prev;
    assign mosi_o      =  stg[STAGES-1][1];
    assign cs_act_o    = ~stg[STAGES-1][2];
    assign clr_o       = ~stg[STAGES-1][3];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_modreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_rise_i,
    input  logic             sclk_fall_i,
    input  logic             mosi_i,
    input  logic             cs_act_i,
    input  logic [REG_W-1:0] rd_data_i,
    output opcode_t          op_o,
    output logic             wr_stb_o,
    output logic [REG_W-1:0] wr_data_o,
    output logic             miso_o
);
    logic [CNT_W-1:0]     cnt;
    logic [BYTE_BITS-2:0] sh;
    logic [REG_W-1:0]     miso_sh;
    logic                 load_pend;
    logic [BYTE_BITS-1:0] byte_in;

    assign byte_in = {sh, mosi_i};

    always_ff @(posedge clk) begin
        wr_stb_o <= 1'b0;
        if (rst) begin
            op_o      <= '0;
            wr_data_o <= '0;
        end
        if (rst || !cs_act_i) begin
            cnt       <= '0;
            sh        <= '0;
            miso_sh   <= '0;
            load_pend <= 1'b0;
        end else begin
            if (sclk_rise_i && cnt != CNT_W'(FRAME_BITS)) begin
                sh  <= byte_in[BYTE_BITS-2:0];
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(BYTE_BITS - 1)) begin
                    op_o      <= opcode_t'(byte_in);
                    load_pend <= 1'b1;
                end
                if (cnt == CNT_W'(FRAME_BITS - 1) && op_o.wr) begin
                    wr_stb_o  <= 1'b1;
                    wr_data_o <= byte_in;
                end
            end
            if (load_pend) begin
                load_pend <= 1'b0;
                miso_sh   <= op_o.wr ? '0 : rd_data_i;
            end else if (sclk_fall_i && cnt > CNT_W'(BYTE_BITS)
                         && cnt < CNT_W'(FRAME_BITS)) begin
                miso_sh <= {miso_sh[REG_W-2:0], 1'b0};
            end
        end
    end

    assign miso_o = miso_sh[REG_W-1];

    // R11
    bit_cap_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FRAME_BITS));
    // R2
    miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_act_i |=> !miso_o);
    // R1
    single_wr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |=> !wr_stb_o);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_modreg_pkg::*;
#(
    parameter logic [REG_W-1:0] SYS_MOD_VER = 8'h11,
    parameter logic [REG_W-1:0] IO_MOD_VER  = 8'h21,
    parameter logic [REG_W-1:0] SMP_MOD_VER = 8'h31,
    parameter logic [REG_W-1:0] SYS_VERSION = 8'h05,
    parameter logic [REG_W-1:0] MANU_CODE   = 8'h5A
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_clr_i,
    input  opcode_t          op_i,
    input  logic             wr_stb_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic             btn_i,
    input  logic [3:0]       cfg_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic [1:0]       led_o,
    output logic [7:0]       pmod_dir_o,
    output logic [7:0]       pmod_val_o,
    output logic [2:0]       rf_mode_o,
    output logic [1:0]       io_dbg_o,
    output logic [3:0]       sync_src_o,
    output logic [3:0]       tx_gap_o,
    output logic [2:0]       dbg_mode_o,
    output logic [3:0]       soft_sync_o,
    output logic             smp_chan_o,
    output logic             smp_dir_o
);
    logic clr;
    logic hit_sys, hit_io, hit_smp;

    assign hit_sys = wr_stb_i && op_i.mod == MOD_SYS;
    assign hit_io  = wr_stb_i && op_i.mod == MOD_IO;
    assign hit_smp = wr_stb_i && op_i.mod == MOD_SMP;
    assign clr     = rst || pin_clr_i || (hit_sys && op_i.idx == IX_CLEAR);

    always_ff @(posedge clk) begin
        if (clr) begin
            led_o       <= '0;
            pmod_dir_o  <= '0;
            pmod_val_o  <= '0;
            rf_mode_o   <= '0;
            io_dbg_o    <= '0;
            sync_src_o  <= '0;
            tx_gap_o    <= '0;
            dbg_mode_o  <= '0;
            soft_sync_o <= '0;
            smp_chan_o  <= 1'b0;
            smp_dir_o   <= 1'b0;
        end else begin
            if (hit_sys) begin
                case (op_i.idx)
                    IX_DBG:      dbg_mode_o <= wr_data_i[2:0];
                    IX_GAP_SYNC: {sync_src_o, tx_gap_o} <= wr_data_i;
                    IX_SSYNC:    soft_sync_o <= wr_data_i[3:0];
                    default: ;
                endcase
            end
            if (hit_io) begin
                case (op_i.idx)
                    IX_IO_MODE: begin
                        io_dbg_o <= wr_data_i[1:0];
                        if (rf_mode_legal(wr_data_i[4:2]))
                            rf_mode_o <= wr_data_i[4:2];
                    end
                    IX_IO_PINS:  led_o      <= wr_data_i[1:0];
                    IX_PMOD_DIR: pmod_dir_o <= wr_data_i;
                    IX_PMOD_VAL: pmod_val_o <= wr_data_i;
                    default: ;
                endcase
            end
            if (hit_smp) begin
                case (op_i.idx)
                    IX_SMP_CHAN: smp_chan_o <= wr_data_i[0];
                    IX_SMP_DIR:  smp_dir_o  <= wr_data_i[0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        case (op_i.mod)
            MOD_SYS: case (op_i.idx)
                IX_VER:      rd_data_o = SYS_MOD_VER;
                IX_SYS_VER:  rd_data_o = SYS_VERSION;
                IX_MANU:     rd_data_o = MANU_CODE;
                IX_DBG:      rd_data_o = {5'd0, dbg_mode_o};
                IX_GAP_SYNC: rd_data_o = {sync_src_o, tx_gap_o};
                IX_SSYNC:    rd_data_o = {4'd0, soft_sync_o};
                default:     rd_data_o = '0;
            endcase
            MOD_IO: case (op_i.idx)
                IX_VER:      rd_data_o = IO_MOD_VER;
                IX_IO_MODE:  rd_data_o = {3'd0, rf_mode_o, io_dbg_o};
                IX_IO_PINS:  rd_data_o = {btn_i, cfg_i, 1'b0, led_o};
                IX_PMOD_DIR: rd_data_o = pmod_dir_o;
                IX_PMOD_VAL: rd_data_o = pmod_val_o;
                default:     rd_data_o = '0;
            endcase
            MOD_SMP: case (op_i.idx)
                IX_VER:      rd_data_o = SMP_MOD_VER;
                IX_SMP_CHAN: rd_data_o = {7'd0, smp_chan_o};
                IX_SMP_DIR:  rd_data_o = {7'd0, smp_dir_o};
                default:     rd_data_o = '0;
            endcase
            default: rd_data_o = '0;
        endcase
    end

    // R6
    rf_range_chk: assert property (@(posedge clk) disable iff (rst)
        rf_mode_o <= RF_MODE_MAX);
    // R12
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        pin_clr_i |=> (pmod_dir_o == 8'h00 && led_o == 2'b00 && tx_gap_o == 4'h0));
    // R8
    pmod_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_io && !pin_clr_i && op_i.idx == IX_PMOD_DIR)
            |=> pmod_dir_o == $past(wr_data_i));
endmodule

// File: rtl/spi_modreg_slave.sv
module spi_modreg_slave
    import spi_modreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk_i,
    input  logic       mosi_i,
    input  logic       cs_n_i,
    output logic       miso_o,
    input  logic       soft_rst_n_i,
    input  logic       btn_i,
    input  logic [3:0] cfg_i,
    output logic [1:0] led_o,
    output logic [7:0] pmod_dir_o,
    output logic [7:0] pmod_val_o,
    output logic [2:0] rf_mode_o,
    output logic [1:0] io_dbg_o,
    output logic [3:0] sync_src_o,
    output logic [3:0] tx_gap_o,
    output logic [2:0] dbg_mode_o,
    output logic [3:0] soft_sync_o,
    output logic       smp_chan_o,
    output logic       smp_dir_o
);
    logic             s_rise, s_fall, s_mosi, s_cs, s_clr;
    opcode_t          op;
    logic             wr_stb;
    logic [REG_W-1:0] wr_data, rd_data;

    spi_pin_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst),
        .sclk_i(sclk_i), .mosi_i(mosi_i), .cs_n_i(cs_n_i), .srst_n_i(soft_rst_n_i),
        .sclk_rise_o(s_rise), .sclk_fall_o(s_fall), .mosi_o(s_mosi),
        .cs_act_o(s_cs), .clr_o(s_clr)
    );

    spi_frame_engine u_frame (
        .clk(clk), .rst(rst),
        .sclk_rise_i(s_rise), .sclk_fall_i(s_fall), .mosi_i(s_mosi), .cs_act_i(s_cs),
        .rd_data_i(rd_data), .op_o(op), .wr_stb_o(wr_stb), .wr_data_o(wr_data),
        .miso_o(miso_o)
    );

    spi_reg_bank u_bank (
        .clk(clk), .rst(rst), .pin_clr_i(s_clr),
        .op_i(op), .wr_stb_i(wr_stb), .wr_data_i(wr_data),
        .btn_i(btn_i), .cfg_i(cfg_i), .rd_data_o(rd_data),
        .led_o(led_o), .pmod_dir_o(pmod_dir_o), .pmod_val_o(pmod_val_o),
        .rf_mode_o(rf_mode_o), .io_dbg_o(io_dbg_o), .sync_src_o(sync_src_o),
        .tx_gap_o(tx_gap_o), .dbg_mode_o(dbg_mode_o), .soft_sync_o(soft_sync_o),
        .smp_chan_o(smp_chan_o), .smp_dir_o(smp_dir_o)
    );
endmodule

// File: tb/tb_spi_modreg_slave.sv
module tb_spi_modreg_slave;
    localparam int HP = 10;   // SCLK half period in system clocks

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1, srst_n = 1'b1;
    logic btn = 1'b1;
    logic [3:0] cfg = 4'b1010;
    logic miso;
    logic [1:0] led, io_dbg;
    logic [7:0] pdir, pval;
    logic [2:0] rf, dbg;
    logic [3:0] sync_src, gap, ssync;
    logic chan, sdir;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    spi_modreg_slave dut (
        .clk(clk), .rst(rst), .sclk_i(sclk), .mosi_i(mosi), .cs_n_i(cs_n),
        .miso_o(miso), .soft_rst_n_i(srst_n), .btn_i(btn), .cfg_i(cfg),
        .led_o(led), .pmod_dir_o(pdir), .pmod_val_o(pval), .rf_mode_o(rf),
        .io_dbg_o(io_dbg), .sync_src_o(sync_src), .tx_gap_o(gap),
        .dbg_mode_o(dbg), .soft_sync_o(ssync), .smp_chan_o(chan), .smp_dir_o(sdir)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // send word[23:0] MSB first for nbits, return the byte seen on bits 8..15
    task automatic xfer(input logic [23:0] word, input int nbits, output logic [7:0] rx);
        rx = '0;
        cs_n = 1'b0;
        tick(HP);
        for (int i = 0; i < nbits; i++) begin
            mosi = word[23-i];
            tick(HP);
            if (i >= 8 && i < 16) rx = {rx[6:0], miso};
            sclk = 1'b1;
            tick(HP);
            sclk = 1'b0;
        end
        tick(HP);
        cs_n = 1'b1;
        tick(2*HP);
    endtask

    task automatic wr(input logic [7:0] op, input logic [7:0] d);
        logic [7:0] rx;
        xfer({op | 8'h80, d, 8'h00}, 16, rx);
    endtask

    task automatic rd(input logic [7:0] op, output logic [7:0] rx);
        xfer({op & 8'h7F, 8'h00, 8'h00}, 16, rx);
    endtask

    // {req, opcode (read form), write data, expected read}
    localparam int NV = 18;
    localparam logic [31:0] VEC [NV] = '{
        {8'd3,  8'h00, 8'hFF, 8'h11},   // R3 system version byte
        {8'd3,  8'h01, 8'h00, 8'h05},   // R3 system version
        {8'd3,  8'h02, 8'hFF, 8'h5A},   // R3 manufacturer code
        {8'd4,  8'h06, 8'hA7, 8'hA7},   // R4 gap + sync selects
        {8'd5,  8'h05, 8'hFF, 8'h07},   // R5 debug modes
        {8'd5,  8'h07, 8'h3C, 8'h0C},   // R5 soft sync
        {8'd3,  8'h20, 8'h00, 8'h21},   // R3 I/O version
        {8'd6,  8'h21, 8'h16, 8'h16},   // R6 dbg 2, rf 5
        {8'd6,  8'h21, 8'h1B, 8'h17},   // R6 rf 6 rejected, dbg 3
        {8'd7,  8'h22, 8'hFE, 8'hD2},   // R7 led 2, btn 1, cfg 1010
        {8'd8,  8'h23, 8'h5A, 8'h5A},   // R8 pmod dir
        {8'd8,  8'h24, 8'hC3, 8'hC3},   // R8 pmod val
        {8'd3,  8'h40, 8'hFF, 8'h31},   // R3 sample version
        {8'd9,  8'h42, 8'hFF, 8'h01},   // R9 channel
        {8'd9,  8'h43, 8'h01, 8'h01},   // R9 direction
        {8'd10, 8'h61, 8'hFF, 8'h00},   // R10 reserved module
        {8'd10, 8'h03, 8'hFF, 8'h00},   // R10 error status
        {8'd10, 8'h2F, 8'hFF, 8'h00}    // R10 undecoded index
    };

    initial begin
        logic [7:0] rx;
        tick(5);
        // R13 reset state
        check("R13 miso", {7'd0, miso}, 8'h00);
        check("R13 outputs", {led, rf, io_dbg, chan}, 8'h00);
        check("R13 pmod", pdir | pval, 8'h00);
        rst = 1'b0;
        tick(5);

        for (int v = 0; v < NV; v++) begin
            logic [7:0] op, wd, ex, req;
            {req, op, wd, ex} = VEC[v];
            xfer({op | 8'h80, wd, 8'h00}, 16, rx);
            check("R2 miso on write", rx, 8'h00);
            rd(op, rx);
            check($sformatf("R%0d read %02h", req, op), rx, ex);
        end

        check("R4 tx_gap", {4'd0, gap}, 8'h07);
        check("R4 sync_src", {4'd0, sync_src}, 8'h0A);
        check("R5 dbg_mode", {5'd0, dbg}, 8'h07);
        check("R5 soft_sync", {4'd0, ssync}, 8'h0C);
        check("R6 rf_mode", {5'd0, rf}, 8'h05);
        check("R6 io_dbg", {6'd0, io_dbg}, 8'h03);
        check("R7 led", {6'd0, led}, 8'h02);
        check("R8 pmod_dir", pdir, 8'h5A);
        check("R8 pmod_val", pval, 8'hC3);
        check("R9 chan/dir", {6'd0, chan, sdir}, 8'h03);
        check("R10 no stray write", {pdir ^ 8'h5A}, 8'h00);

        // R11 abort after 12 bits
        xfer({8'hA3, 8'h00, 8'h00}, 12, rx);
        check("R11 aborted frame", pdir, 8'h5A);
        // R11 extra bits ignored
        xfer({8'hA4, 8'h11, 8'hFF}, 24, rx);
        check("R11 extra bits", pval, 8'h11);
        // R1 read of the long-frame result
        rd(8'h24, rx);
        check("R1 readback", rx, 8'h11);

        // R12 clear by register write
        wr(8'h04, 8'h00);
        check("R12 clear led", {6'd0, led}, 8'h00);
        check("R12 clear pmod", pdir | pval, 8'h00);
        check("R12 clear rf/gap", {1'b0, rf, gap}, 8'h00);
        rd(8'h04, rx);
        check("R12 index 4 reads 0", rx, 8'h00);

        // R12 clear by pin
        wr(8'h23, 8'h77);
        check("R8 rewrite", pdir, 8'h77);
        srst_n = 1'b0;
        tick(10);
        check("R12 pin clear", pdir, 8'h00);
        // R12 write while clear active is lost
        wr(8'h23, 8'h66);
        srst_n = 1'b1;
        tick(10);
        check("R12 clear beats write", pdir, 8'h00);
        wr(8'h23, 8'h66);
        check("R12 write after release", pdir, 8'h66);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule